// File: doc/BRIEF.md
# Predecoded Byte Queue with Four-Slot R-op Issue

This block sits between the instruction cache and four identical decode positions. Every cycle the cache may hand it up to sixteen bytes of predecoded instruction stream. Each byte carries a flag that marks it as the first byte of an instruction, and a first byte also carries the number of R-ops that instruction expands into. The queue keeps these bytes in order. Each cycle it walks forward from the head. Instruction lengths come from the distance between consecutive start flags. It fills up to four R-op slots in program order, so one group may hold several short instructions, one instruction, or the tail of one.

Each issued slot reports the stream position of its instruction's first byte, the R-op's index within that instruction, the instruction's first byte, and whether the slot came from the microcode sequencer. An instruction that needs one to three R-ops expands straight from the queue. An instruction that needs more is removed from the queue and given to an internal sequencer, which then issues four R-ops per cycle until the count is used up. If the head tags make no sense, the block raises a one-cycle confused pulse, which also serves as the refetch request, and drops everything queued.

Top module: `bq_rop_issue`

## Requirements
- R1: After reset the block shows in_ready high, no slot valid, and confused low.
- R2: The queue holds 32 bytes. in_ready is high exactly when at least 16 entries are free and no flush is happening. A beat of in_cnt bytes is taken only in a cycle where in_valid and in_ready are both high.
- R3: Valid slots are packed from slot 0 and appear in program order. Each slot gives the stream position of its instruction's first byte, counted in accepted bytes since reset. It also gives the R-op index, starting at 0, and the instruction's first byte. slot_ucode is low for fast R-ops.
- R4: One cycle may issue R-ops of several instructions, up to four in total, when every one of those instructions is complete in the queue. An instruction is complete when the next start flag is also queued.
- R5: A fast instruction (1 to 3 R-ops) whose R-ops do not fit in one cycle finishes in the next cycle from slot 0. Its bytes are released only after its last R-op issues.
- R6: An instruction with more than 3 R-ops issues no slots in the cycle it reaches the head. In the following cycles it issues four R-ops per cycle with slot_ucode high and indices that continue across cycles, then a final partial group. Queue issue resumes in the next cycle.
- R7: An instruction with more than 3 R-ops that is not at the head ends the current group before it.
- R8: A head byte without a start flag raises confused for one cycle with in_ready low. The queue then empties.
- R9: confused is raised when 16 or more bytes are queued and no start flag follows the head within 15 bytes. With fewer bytes queued the block just waits.
- R10: confused is raised when the head start byte declares zero R-ops.
- R11: While stall is high no slot is valid and no queued byte or partial progress is lost. Input may still be accepted.
- R12: Bytes discarded by a flush still count toward the stream position of later instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_cnt | input | 5 | Number of valid bytes in the beat, 1 to 16 |
| in_data | input | 128 | Beat bytes, byte j in bits 8j+7:8j |
| in_start | input | 16 | Start-of-instruction flag per byte |
| in_nrop | input | 64 | R-op count per byte, 4 bits each, used on start bytes |
| in_ready | output | 1 | Beat can be accepted this cycle |
| stall | input | 1 | Freeze issue |
| slot_valid | output | 4 | Slot carries an R-op |
| slot_ucode | output | 4 | Slot issued by the microcode sequencer |
| slot_pos | output | 64 | Per slot, 16-bit stream position of the instruction start |
| slot_idx | output | 16 | Per slot, 4-bit R-op index |
| slot_byte | output | 32 | Per slot, first byte of the instruction |
| confused | output | 1 | Tag inconsistency seen; queue flushed, refetch needed |

## Verification
The bench builds the block with its default parameters: a 32-byte queue, 16-byte beats, four slots, 15-byte maximum length and a fast limit of three R-ops. With these values, two full beats reach the backpressure point, a single beat can fill a whole group with short instructions, and an R-op count of 10 takes one entry cycle plus three sequencer cycles. Sixteen queued bytes with only one start flag are enough to reach the overrun check. Random streams with lengths of 1 to 15 bytes, uneven beat sizes and random stalls then push instruction splits across beat boundaries and queue wrap-around.

// File: rtl/bq_rop_issue.sv
module bq_rop_issue #(
  parameter int DEPTH    = 32,
  parameter int IN_BYTES = 16,
  parameter int SLOTS    = 4,
  parameter int MAX_LEN  = 15,
  parameter int FAST_MAX = 3,
  parameter int NROP_W   = 4,
  parameter int POS_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [$clog2(IN_BYTES+1)-1:0] in_cnt,
  input  logic [IN_BYTES*8-1:0]       in_data,
  input  logic [IN_BYTES-1:0]         in_start,
  input  logic [IN_BYTES*NROP_W-1:0]  in_nrop,
  output logic                        in_ready,
  input  logic                        stall,
  output logic [SLOTS-1:0]            slot_valid,
  output logic [SLOTS-1:0]            slot_ucode,
  output logic [SLOTS*POS_W-1:0]      slot_pos,
  output logic [SLOTS*NROP_W-1:0]     slot_idx,
  output logic [SLOTS*8-1:0]          slot_byte,
  output logic                        confused
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]        q_data [DEPTH];
  logic [NROP_W-1:0] q_nrop [DEPTH];
  logic [DEPTH-1:0]  q_start;
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;
  logic [NROP_W-1:0] done_q;
  logic [POS_W-1:0]  head_pos;

  logic              mc_act;
  logic [NROP_W-1:0] mc_left, mc_idx;
  logic [POS_W-1:0]  mc_pos;
  logic [7:0]        mc_byte;

  logic [SLOTS-1:0]             sv, su;
  logic [SLOTS-1:0][POS_W-1:0]  sp;
  logic [SLOTS-1:0][NROP_W-1:0] si;
  logic [SLOTS-1:0][7:0]        sb;
  logic [CW-1:0]     pop;
  logic [NROP_W-1:0] done_n, mc_n;
  logic              mc_go, conf, wr_en;
  logic [POS_W-1:0]  mc_p;
  logic [7:0]        mc_b;

  always_comb begin
    int off, used, len, cur;
    logic go;
    logic [AW-1:0] hidx;
    sv = '0; su = '0; sp = '0; si = '0; sb = '0;
    pop = '0; done_n = done_q; conf = 1'b0;
    mc_go = 1'b0; mc_n = '0; mc_p = '0; mc_b = '0;
    off = 0; used = 0; len = 0; cur = 0; hidx = '0;
    go = !stall && !mc_act;
    for (int i = 0; i < SLOTS; i++) begin
      if (go) begin
        if (off >= int'(count)) go = 1'b0;
        else begin
          hidx = rd_ptr + AW'(off);
          len = 0;
          for (int k = MAX_LEN; k >= 1; k--)
            if (off + k < int'(count) && q_start[AW'(rd_ptr + AW'(off + k))]) len = k;
          if (i == 0 && (!q_start[hidx] || q_nrop[hidx] == '0 ||
                         (len == 0 && int'(count) > MAX_LEN))) begin
            conf = 1'b1;
            go = 1'b0;
          end else if (len == 0 || q_nrop[hidx] == '0) begin
            go = 1'b0;
          end else if (int'(q_nrop[hidx]) > FAST_MAX) begin
            if (i == 0) begin
              mc_go = 1'b1;
              mc_n  = q_nrop[hidx];
              mc_p  = head_pos;
              mc_b  = q_data[hidx];
              pop   = CW'(len);
            end
            go = 1'b0;
          end else begin
            cur = (i == 0) ? int'(done_q) : 0;
            for (int r = 0; r < SLOTS; r++) begin
              if (used < SLOTS && cur < int'(q_nrop[hidx])) begin
                sv[used] = 1'b1;
                sp[used] = head_pos + POS_W'(off);
                si[used] = NROP_W'(cur);
                sb[used] = q_data[hidx];
                used++;
                cur++;
              end
            end
            if (cur == int'(q_nrop[hidx])) begin
              off = off + len;
              pop = CW'(off);
              done_n = '0;
            end else begin
              done_n = NROP_W'(cur);
              go = 1'b0;
            end
          end
        end
      end
    end
    if (mc_act && !stall) begin
      for (int r = 0; r < SLOTS; r++) begin
        if (r < int'(mc_left)) begin
          sv[r] = 1'b1;
          su[r] = 1'b1;
          sp[r] = mc_pos;
          si[r] = mc_idx + NROP_W'(r);
          sb[r] = mc_byte;
        end
      end
    end
  end

  assign in_ready   = (int'(count) <= DEPTH - IN_BYTES) && !conf;
  assign wr_en      = in_valid && in_ready;
  assign confused   = conf;
  assign slot_valid = sv;
  assign slot_ucode = su;
  assign slot_pos   = sp;
  assign slot_idx   = si;
  assign slot_byte  = sb;

  always_ff @(posedge clk) begin
    for (int j = 0; j < IN_BYTES; j++) begin
      if (wr_en && j < int'(in_cnt)) begin
        q_data[AW'(wr_ptr + AW'(j))]  <= in_data[j*8 +: 8];
        q_nrop[AW'(wr_ptr + AW'(j))]  <= in_nrop[j*NROP_W +: NROP_W];
        q_start[AW'(wr_ptr + AW'(j))] <= in_start[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      done_q   <= '0;
      head_pos <= '0;
      mc_act   <= 1'b0;
      mc_left  <= '0;
      mc_idx   <= '0;
      mc_pos   <= '0;
      mc_byte  <= '0;
    end else begin
      if (conf) begin
        rd_ptr   <= wr_ptr;
        count    <= '0;
        done_q   <= '0;
        head_pos <= head_pos + POS_W'(count);
      end else begin
        rd_ptr   <= rd_ptr + AW'(pop);
        count    <= count - pop + (wr_en ? CW'(in_cnt) : CW'(0));
        head_pos <= head_pos + POS_W'(pop);
        done_q   <= done_n;
      end
      if (wr_en) wr_ptr <= wr_ptr + AW'(in_cnt);
      if (mc_go) begin
        mc_act  <= 1'b1;
        mc_left <= mc_n;
        mc_idx  <= '0;
        mc_pos  <= mc_p;
        mc_byte <= mc_b;
      end else if (mc_act && !stall) begin
        if (int'(mc_left) <= SLOTS) begin
          mc_act  <= 1'b0;
          mc_left <= '0;
        end else begin
          mc_left <= mc_left - NROP_W'(SLOTS);
        end
        mc_idx <= mc_idx + NROP_W'(SLOTS);
      end
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    confused |=> count == '0);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !(in_valid && in_ready) |=> count == $past(count));

  p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> slot_valid == '0);

  p_mc_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_act && !stall && int'(mc_left) > SLOTS |-> $countones(slot_valid) == SLOTS);

  generate
    for (genvar g = 1; g < SLOTS; g++) begin : g_pack
      p_packed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[g] |-> slot_valid[g-1]);
    end
  endgenerate
endmodule

// File: tb/tb_bq_rop_issue.sv
module tb_bq_rop_issue;
  localparam int CLK_PERIOD = 10;
  localparam int IN_BYTES = 16;
  localparam int SLOTS = 4;
  localparam int NROP_W = 4;
  localparam int POS_W = 16;
  localparam int SMAX = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [4:0] in_cnt = '0;
  logic [IN_BYTES*8-1:0] in_data = '0;
  logic [IN_BYTES-1:0] in_start = '0;
  logic [IN_BYTES*NROP_W-1:0] in_nrop = '0;
  logic in_ready, stall = 1'b0, confused;
  logic [SLOTS-1:0] slot_valid, slot_ucode;
  logic [SLOTS*POS_W-1:0] slot_pos;
  logic [SLOTS*NROP_W-1:0] slot_idx;
  logic [SLOTS*8-1:0] slot_byte;

  bq_rop_issue dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cnt(in_cnt),
    .in_data(in_data), .in_start(in_start), .in_nrop(in_nrop),
    .in_ready(in_ready), .stall(stall), .slot_valid(slot_valid),
    .slot_ucode(slot_ucode), .slot_pos(slot_pos), .slot_idx(slot_idx),
    .slot_byte(slot_byte), .confused(confused)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] s_data [SMAX];
  bit s_st [SMAX];
  int s_nr [SMAX];
  int s_len, s_wr;
  int e_pos [SMAX], e_idx [SMAX], e_byte [SMAX];
  bit e_mc [SMAX];
  int e_wr, e_rd;
  bit pend; int pend_pos, pend_nr, pend_byte;
  bit feed_en, rand_cnt, stall_hold, conf_ok;
  int stall_pct;
  int cyc_nv; bit cyc_ready, cyc_conf;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_byte(bit st, int nr, int b);
    s_data[s_len] = 8'(b); s_st[s_len] = st; s_nr[s_len] = nr;
    s_len++;
  endtask

  task automatic add_instr(int len, int nr, int op);
    if (pend) begin
      for (int r = 0; r < pend_nr; r++) begin
        e_pos[e_wr] = pend_pos; e_idx[e_wr] = r; e_byte[e_wr] = pend_byte;
        e_mc[e_wr] = (pend_nr > 3); e_wr++;
      end
    end
    pend = 1; pend_pos = s_len; pend_nr = nr; pend_byte = op & 8'hff;
    add_byte(1'b1, nr, op);
    for (int j = 1; j < len; j++) add_byte(1'b0, 0, int'($urandom_range(255)));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; stall = 1'b0;
    feed_en = 0; rand_cnt = 0; stall_hold = 0; stall_pct = 0; conf_ok = 1;
    s_len = 0; s_wr = 0; e_wr = 0; e_rd = 0; pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tick();
    int k;
    @(negedge clk);
    stall = stall_hold || (int'($urandom_range(99)) < stall_pct);
    k = 0;
    in_valid = 1'b0; in_data = '0; in_start = '0; in_nrop = '0; in_cnt = '0;
    if (feed_en && s_wr < s_len) begin
      k = s_len - s_wr;
      if (k > IN_BYTES) k = IN_BYTES;
      if (rand_cnt) k = int'($urandom_range(k, 1));
      in_valid = 1'b1; in_cnt = 5'(k);
      for (int j = 0; j < IN_BYTES; j++) if (j < k) begin
        in_data[j*8 +: 8] = s_data[s_wr+j];
        in_start[j] = s_st[s_wr+j];
        in_nrop[j*NROP_W +: NROP_W] = NROP_W'(s_nr[s_wr+j]);
      end
    end
    #1;
    cyc_nv = 0;
    for (int j = 0; j < SLOTS; j++) begin
      if (slot_valid[j]) begin
        cyc_nv++;
        if (e_rd >= e_wr) chk(0, "R3", "unexpected slot pos", int'(slot_pos[j*POS_W +: POS_W]), -1);
        else begin
          chk(int'(slot_pos[j*POS_W +: POS_W]) == e_pos[e_rd], "R3", "slot pos",
              int'(slot_pos[j*POS_W +: POS_W]), e_pos[e_rd]);
          chk(int'(slot_idx[j*NROP_W +: NROP_W]) == e_idx[e_rd], "R3", "slot idx",
              int'(slot_idx[j*NROP_W +: NROP_W]), e_idx[e_rd]);
          chk(int'(slot_byte[j*8 +: 8]) == e_byte[e_rd], "R3", "slot byte",
              int'(slot_byte[j*8 +: 8]), e_byte[e_rd]);
          chk(slot_ucode[j] == e_mc[e_rd], "R6", "ucode flag", int'(slot_ucode[j]), int'(e_mc[e_rd]));
          e_rd++;
        end
      end
    end
    cyc_ready = in_ready; cyc_conf = confused;
    if (conf_ok && confused) chk(0, "R9", "unexpected confused", 1, 0);
    if (in_valid && in_ready) s_wr += k;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f3a));
    // R1 reset state
    do_reset();
    tick();
    chk(cyc_ready == 1, "R1", "ready after reset", int'(cyc_ready), 1);
    chk(cyc_nv == 0, "R1", "slots after reset", cyc_nv, 0);
    chk(cyc_conf == 0, "R1", "confused after reset", int'(cyc_conf), 0);

    // R4 four short instructions in one group
    do_reset();
    add_instr(2, 1, 8'h11); add_instr(1, 1, 8'h22); add_instr(3, 1, 8'h33);
    add_instr(1, 1, 8'h44); add_instr(1, 1, 8'h55);
    feed_en = 1;
    tick(); tick();
    chk(cyc_nv == 4, "R4", "group of four", cyc_nv, 4);
    tick();
    chk(cyc_nv == 0, "R4", "incomplete tail waits", cyc_nv, 0);
    chk(e_rd == e_wr, "R3", "all issued", e_rd, e_wr);

    // R5 split across cycles
    do_reset();
    add_instr(2, 3, 8'h61); add_instr(1, 3, 8'h62); add_instr(1, 1, 8'h63);
    feed_en = 1;
    tick(); tick();
    chk(cyc_nv == 4, "R5", "first group", cyc_nv, 4);
    tick();
    chk(cyc_nv == 2, "R5", "remainder", cyc_nv, 2);
    tick();
    chk(cyc_nv == 0, "R5", "nothing after", cyc_nv, 0);
    chk(e_rd == e_wr, "R5", "all issued", e_rd, e_wr);

    // R6, R7 microcode handoff
    do_reset();
    add_instr(1, 1, 8'h71); add_instr(3, 10, 8'h72); add_instr(2, 2, 8'h73);
    add_instr(1, 1, 8'h74);
    feed_en = 1;
    tick(); tick();
    chk(cyc_nv == 1, "R7", "group stops before trap", cyc_nv, 1);
    tick();
    chk(cyc_nv == 0, "R6", "entry cycle", cyc_nv, 0);
    tick();
    chk(cyc_nv == 4, "R6", "seq cycle 1", cyc_nv, 4);
    tick();
    chk(cyc_nv == 4, "R6", "seq cycle 2", cyc_nv, 4);
    tick();
    chk(cyc_nv == 2, "R6", "seq last", cyc_nv, 2);
    tick();
    chk(cyc_nv == 2, "R6", "queue resumes", cyc_nv, 2);
    chk(e_rd == e_wr, "R6", "all issued", e_rd, e_wr);

    // R11 stall freezes issue
    do_reset();
    stall_hold = 1;
    add_instr(1, 1, 8'h81); add_instr(2, 1, 8'h82); add_instr(1, 1, 8'h83);
    add_instr(1, 1, 8'h84);
    feed_en = 1;
    for (int t = 0; t < 3; t++) begin
      tick();
      chk(cyc_nv == 0, "R11", "no slot while stalled", cyc_nv, 0);
    end
    stall_hold = 0;
    tick();
    chk(cyc_nv == 3, "R11", "issue after stall", cyc_nv, 3);

    // R2 backpressure
    do_reset();
    stall_hold = 1;
    for (int n = 0; n < 12; n++) add_instr(4, 1, 8'h90 + n);
    add_instr(1, 1, 8'h9f);
    feed_en = 1;
    tick();
    chk(cyc_ready == 1, "R2", "ready empty", int'(cyc_ready), 1);
    tick();
    chk(cyc_ready == 1, "R2", "ready at 16 free", int'(cyc_ready), 1);
    tick();
    chk(cyc_ready == 0, "R2", "ready when full", int'(cyc_ready), 0);
    tick();
    chk(cyc_ready == 0, "R2", "ready stays low", int'(cyc_ready), 0);
    stall_hold = 0;
    for (int t = 0; t < 30; t++) tick();
    chk(e_rd == e_wr, "R2", "stream intact after backpressure", e_rd, e_wr);

    // R8, R12 head without start flag
    do_reset();
    conf_ok = 0;
    add_byte(1'b0, 0, 8'hee); add_byte(1'b0, 0, 8'hee); add_byte(1'b0, 0, 8'hee);
    feed_en = 1;
    tick(); tick();
    chk(cyc_conf == 1, "R8", "confused on bad head", int'(cyc_conf), 1);
    chk(cyc_ready == 0, "R8", "ready low during flush", int'(cyc_ready), 0);
    tick();
    chk(cyc_conf == 0, "R8", "confused one cycle", int'(cyc_conf), 0);
    chk(cyc_nv == 0, "R8", "queue empty", cyc_nv, 0);
    conf_ok = 1;
    add_instr(2, 1, 8'hab); add_instr(1, 1, 8'hac);
    tick(); tick();
    chk(cyc_nv == 1, "R12", "issue after flush at position 3", cyc_nv, 1);
    chk(e_rd == e_wr, "R12", "all issued", e_rd, e_wr);

    // R9 overrun
    do_reset();
    conf_ok = 0;
    add_byte(1'b1, 1, 8'h01);
    for (int j = 0; j < 14; j++) add_byte(1'b0, 0, 8'h02);
    feed_en = 1;
    tick(); tick();
    chk(cyc_conf == 0, "R9", "15 bytes wait", int'(cyc_conf), 0);
    chk(cyc_nv == 0, "R9", "15 bytes no issue", cyc_nv, 0);
    add_byte(1'b0, 0, 8'h03);
    tick(); tick();
    chk(cyc_conf == 1, "R9", "16 bytes no boundary", int'(cyc_conf), 1);

    // R10 zero R-op count
    do_reset();
    conf_ok = 0;
    add_byte(1'b1, 0, 8'h05); add_byte(1'b1, 1, 8'h06);
    feed_en = 1;
    tick(); tick();
    chk(cyc_conf == 1, "R10", "zero count confuses", int'(cyc_conf), 1);

    // random mix
    do_reset();
    stall_pct = 20; rand_cnt = 1;
    for (int n = 0; n < 300; n++) begin
      int len, nr;
      len = int'($urandom_range(15, 1));
      nr = (int'($urandom_range(99)) < 85) ? int'($urandom_range(3, 1)) : int'($urandom_range(15, 4));
      add_instr(len, nr, int'($urandom_range(255)));
    end
    add_instr(1, 1, 8'h00);
    feed_en = 1;
    for (int t = 0; t < 20000 && e_rd < e_wr; t++) tick();
    chk(e_rd == e_wr, "R3", "random stream fully issued", e_rd, e_wr);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule